// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a four-wire serial slave that gives a host access to a bank of sixteen 8-bit configuration registers. It has an active-low select, a serial clock, a data input and a data output. All three host pins are sampled on a free-running master clock. The serial clock is therefore never used as a clock, and the whole block runs in one clock domain. The register contents leave the block as a flat vector, so that the functions they control can use them.

A frame is the period during which the select pin is low. Each frame carries a 13-bit command word: a direction bit, a 4-bit address, then 8 data bits, with the earliest bit first. The host may send more than 13 bits, and only the last 13 before the select pin rises are decoded. A write is applied when the select pin rises. Reads are deferred by one frame. In every frame, the register named by the previous valid frame is shifted out, most significant bit first. This happens whether that previous frame was a read or a write.

Two bits of the control register change how the port behaves. One enables the serial output driver. The other protects the four offset registers from writes.

The block has no valid/ready stream interface. The serial pins follow the host's own timing, and every other pin is plain control or status.

Top module: `cfg_serial_port`

## Requirements
- R1: An active-high synchronous `rst` loads every register with its default. Address 8 (control register) defaults to 0x4E, address 14 to 0xAA and address 15 to 0x5A. All other addresses default to 0x00.
- R2: Data is sampled on each rising edge of `ser_clk` while `ser_cs_n` is low. The word has 13 bits, earliest first: bit 12 is the direction bit (0 means write), bits 11:8 are the address (most significant first) and bits 7:0 are the data (most significant first). A write frame stores its data at its address when `ser_cs_n` rises.
- R3: When more than 13 bits arrive in one frame, only the last 13 are decoded and the earlier bits are discarded.
- R4: A frame with fewer than 13 bits changes no register and does not change the address used for the next readback.
- R5: A frame whose direction bit is 1 is a read, and its 8 data bits change no register.
- R6: In the frame that follows a valid frame, the register at that earlier frame's address is shifted out on `ser_dout`, most significant bit first. This applies to both read and write frames, and a write frame reads back its newly written value. The first bit is present once the select pin is low and before the first `ser_clk` rise. Each falling edge of `ser_clk` advances the output by one bit. After reset, readback uses address 0.
- R7: `ser_dout_oe` is high only while `ser_cs_n` is low and bit 6 of the control register (address 8) is set. `ser_dout` is 0 whenever `ser_dout_oe` is low.
- R8: While bit 3 of the control register is set, writes to addresses 4 through 7 are ignored.
- R9: `ser_clk` edges while `ser_cs_n` is high have no effect. Each frame starts with no captured bits.
- R10: The host pins pass through a two-flop synchronizer. No register changes while `ser_cs_n` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all pins are oversampled on it |
| rst | input | 1 | Active-high synchronous reset to register defaults |
| ser_cs_n | input | 1 | Active-low frame select from the host |
| ser_clk | input | 1 | Serial bit clock from the host |
| ser_din | input | 1 | Serial command data from the host |
| ser_dout | output | 1 | Serial readback data, most significant bit first |
| ser_dout_oe | output | 1 | Output driver enable for `ser_dout` |
| cfg_regs | output | NUM_REGS*DATA_W | All registers; address a occupies bits a*DATA_W+DATA_W-1 down to a*DATA_W |

## Verification
The bench builds the block with its default values of 16 registers, 8 data bits and two synchronizer stages. With these values the sweep can visit every address, both as a read and as a write, and can check each register's default through the deferred readback path. Because the register bank is this small, the full bank is compared against an arithmetic model after every frame. This size also brings the control register's two mode bits into reach: offset protection on and then off, and output enable on and then off. The remaining frames cover long frames, short frames, and clock activity while the select pin is high.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  localparam int unsigned CFG_DATA_W  = 8;
  localparam int unsigned CTRL_ADDR   = 8;
  localparam int unsigned OE_BIT      = 6;
  localparam int unsigned AUTOCAL_BIT = 3;
  localparam int unsigned OFS_FIRST   = 4;
  localparam int unsigned OFS_COUNT   = 4;
  localparam int unsigned PWR0_ADDR   = 14;
  localparam int unsigned PWR1_ADDR   = 15;

  function automatic logic [CFG_DATA_W-1:0] reg_default(input int unsigned addr);
    if (addr == CTRL_ADDR) return 8'h4E;
    if (addr == PWR0_ADDR) return 8'hAA;
    if (addr == PWR1_ADDR) return 8'h5A;
    return '0;
  endfunction
endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= INIT;
    end else begin
      stage_q[0] <= pin_async;
      for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_frame_shifter.sv
module cfg_frame_shifter #(
  parameter int unsigned FRAME_W = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] word,
  output logic               full
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] word_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (shift_en) begin
      word_q <= {word_q[FRAME_W-2:0], bit_in};
      if (cnt_q != CNT_W'(FRAME_W)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word = word_q;
  assign full = (cnt_q == CNT_W'(FRAME_W));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_serial_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned DATA_W   = CFG_DATA_W,
  parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  logic protect_ofs;
  assign protect_ofs = regs_flat[CTRL_ADDR*DATA_W + AUTOCAL_BIT];

  for (genvar i = 0; i < int'(NUM_REGS); i++) begin : g_reg
    localparam bit IS_OFS = (i >= int'(OFS_FIRST)) && (i < int'(OFS_FIRST + OFS_COUNT));
    logic [DATA_W-1:0] val_q;
    logic              hit;
    logic              blocked;

    assign hit     = wr_en && (wr_addr == ADDR_W'(i));
    assign blocked = IS_OFS && protect_ofs;

    always_ff @(posedge clk) begin
      if (rst)                 val_q <= DATA_W'(reg_default(i));
      else if (hit && !blocked) val_q <= wr_data;
    end

    assign regs_flat[i*DATA_W +: DATA_W] = val_q;
  end
endmodule

// File: rtl/cfg_readback.sv
module cfg_readback #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  output logic              msb
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)        sh_q <= '0;
    else if (load)  sh_q <= load_data;
    else if (shift) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
  end

  assign msb = sh_q[DATA_W-1];
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_serial_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 16,
  parameter int unsigned DATA_W      = CFG_DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ser_cs_n,
  input  logic                       ser_clk,
  input  logic                       ser_din,
  output logic                       ser_dout,
  output logic                       ser_dout_oe,
  output logic [NUM_REGS*DATA_W-1:0] cfg_regs
);
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS);
  localparam int unsigned FRAME_W = 1 + ADDR_W + DATA_W;

  logic [2:0] pins_s;
  logic cs_s, sclk_s, din_s;
  logic cs_d, sclk_d;

  cfg_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b001)) u_sync (
    .clk(clk), .rst(rst),
    .pin_async({ser_din, ser_clk, ser_cs_n}),
    .pin_sync(pins_s)
  );
  assign {din_s, sclk_s, cs_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  logic cs_fall, cs_rise, sclk_rise, sclk_fall;
  assign cs_fall   = !cs_s && cs_d;
  assign cs_rise   = cs_s && !cs_d;
  assign sclk_rise = !cs_s && sclk_s && !sclk_d;
  assign sclk_fall = !cs_s && !sclk_s && sclk_d;

  logic [FRAME_W-1:0] word;
  logic               full;

  cfg_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .clear(cs_fall), .shift_en(sclk_rise),
    .bit_in(din_s), .word(word), .full(full)
  );

  logic              commit;
  logic              is_read;
  logic [ADDR_W-1:0] frame_addr;
  logic [DATA_W-1:0] frame_data;
  assign commit     = cs_rise && full;
  assign is_read    = word[FRAME_W-1];
  assign frame_addr = word[DATA_W +: ADDR_W];
  assign frame_data = word[DATA_W-1:0];

  cfg_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(commit && !is_read),
    .wr_addr(frame_addr), .wr_data(frame_data), .regs_flat(cfg_regs)
  );

  logic [ADDR_W-1:0] rb_addr_q;
  always_ff @(posedge clk) begin
    if (rst)         rb_addr_q <= '0;
    else if (commit) rb_addr_q <= frame_addr;
  end

  logic rb_msb;
  cfg_readback #(.DATA_W(DATA_W)) u_rb (
    .clk(clk), .rst(rst), .load(cs_fall),
    .load_data(cfg_regs[rb_addr_q*DATA_W +: DATA_W]),
    .shift(sclk_fall), .msb(rb_msb)
  );

  assign ser_dout_oe = !cs_s && cfg_regs[CTRL_ADDR*DATA_W + OE_BIT];
  assign ser_dout    = ser_dout_oe && rb_msb;
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk
  import cfg_serial_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned DATA_W   = CFG_DATA_W
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       ser_cs_n,
  input logic                       ser_dout,
  input logic                       ser_dout_oe,
  input logic [NUM_REGS*DATA_W-1:0] cfg_regs
);
  localparam int unsigned OFS_LO = OFS_FIRST * DATA_W;
  localparam int unsigned OFS_SZ = OFS_COUNT * DATA_W;

  p_defaults_r1: assert property (@(posedge clk)
    rst |=> (cfg_regs[CTRL_ADDR*DATA_W +: DATA_W] == DATA_W'(8'h4E)));

  p_dout_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !ser_dout_oe |-> !ser_dout);

  p_oe_enable_r7: assert property (@(posedge clk) disable iff (rst)
    ser_dout_oe |-> cfg_regs[CTRL_ADDR*DATA_W + OE_BIT]);

  p_ofs_locked_r8: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_regs[CTRL_ADDR*DATA_W + AUTOCAL_BIT])
      |-> (cfg_regs[OFS_LO +: OFS_SZ] == $past(cfg_regs[OFS_LO +: OFS_SZ])));

  p_stable_in_frame_r10: assert property (@(posedge clk) disable iff (rst)
    (!ser_cs_n && !$past(ser_cs_n, 1) && !$past(ser_cs_n, 2) && !$past(ser_cs_n, 3)
      && !$past(ser_cs_n, 4) && !$past(ser_cs_n, 5)) |-> $stable(cfg_regs));
endmodule

bind cfg_serial_port cfg_serial_port_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ser_cs_n(ser_cs_n), .ser_dout(ser_dout),
  .ser_dout_oe(ser_dout_oe), .cfg_regs(cfg_regs)
);

// File: tb/cfg_serial_port_tb.sv
module cfg_serial_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_cs_n = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_din = 1'b0;
  logic ser_dout, ser_dout_oe;
  logic [127:0] cfg_regs;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] model [16];
  logic [3:0] rb_addr;

  always #5 clk = ~clk;

  cfg_serial_port u_dut (
    .clk(clk), .rst(rst), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe), .cfg_regs(cfg_regs)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] model_flat();
    logic [127:0] f;
    for (int a = 0; a < 16; a++) f[a*8 +: 8] = model[a];
    return f;
  endfunction

  function automatic logic [7:0] dflt(input int a);
    if (a == 8) return 8'h4E;
    if (a == 14) return 8'hAA;
    if (a == 15) return 8'h5A;
    return 8'h00;
  endfunction

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input int nbits, input logic [31:0] bits, input string tag);
    logic [7:0] rd;
    logic oe0, exp_oe;
    logic [7:0] exp_rd;
    logic [12:0] w;
    exp_oe = model[8][6];
    exp_rd = exp_oe ? model[rb_addr] : 8'h00;
    rd = 8'h00;
    ser_cs_n = 1'b0;
    waitn(6);
    oe0 = ser_dout_oe;
    for (int i = 0; i < nbits; i++) begin
      ser_clk = 1'b0;
      ser_din = bits[nbits-1-i];
      waitn(6);
      if (i < 8) rd[7-i] = ser_dout;
      ser_clk = 1'b1;
      waitn(6);
    end
    ser_clk = 1'b0;
    waitn(6);
    check(cfg_regs == model_flat(), "R10 regs changed while selected", cfg_regs, model_flat());
    ser_cs_n = 1'b1;
    waitn(8);
    check(ser_dout_oe == 1'b0, "R7 oe while deselected", 128'(ser_dout_oe), 128'(0));
    check(oe0 == exp_oe, "R7 oe in frame", 128'(oe0), 128'(exp_oe));
    if (nbits >= 8) check(rd == exp_rd, "R6 readback", 128'(rd), 128'(exp_rd));
    if (nbits >= 13) begin
      w = bits[12:0];
      if (!w[12] && !((w[11:8] >= 4 && w[11:8] <= 7) && model[8][3]))
        model[w[11:8]] = w[7:0];
      rb_addr = w[11:8];
    end
    check(cfg_regs == model_flat(), tag, cfg_regs, model_flat());
  endtask

  task automatic wr(input int a, input logic [7:0] d, input string tag);
    run_frame(13, {19'b0, 1'b0, 4'(a), d}, tag);
  endtask

  task automatic rdf(input int a, input logic [7:0] junk, input string tag);
    run_frame(13, {19'b0, 1'b1, 4'(a), junk}, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 16; a++) model[a] = dflt(a);
    rb_addr = 4'd0;
    waitn(5);
    rst = 1'b0;
    waitn(4);
    for (int a = 0; a < 16; a++)
      check(cfg_regs[a*8 +: 8] == dflt(a), "R1 reset default", 128'(cfg_regs[a*8 +: 8]), 128'(dflt(a)));
    check(ser_dout_oe == 1'b0, "R7 oe idle after reset", 128'(ser_dout_oe), 128'(0));

    // Read every address with junk data bits; readback trails by one frame
    for (int a = 0; a < 16; a++) rdf(a, 8'(a * 29 + 3), "R5 read leaves bank");
    rdf(0, 8'hFF, "R5 read leaves bank");

    // Writes with offset protection on: offsets stay
    for (int a = 0; a < 16; a++) begin
      if (a == 8) continue;
      wr(a, 8'((a * 37 + 5) & 8'hFF), (a >= 4 && a <= 7) ? "R8 protected offset" : "R2 write");
    end
    rdf(5, 8'h00, "R8 protected readback");
    // Clear protection, keep output enabled
    wr(8, 8'h40, "R2 write control");
    for (int a = 4; a < 8; a++) wr(a, 8'((a * 53 + 1) & 8'hFF), "R8 unprotected offset");
    rdf(0, 8'h00, "R6 write frame readback");

    // Long frame: 7 leading junk ones
    run_frame(20, {12'b0, 7'h7F, 1'b0, 4'd3, 8'h96}, "R3 long frame");
    rdf(3, 8'h00, "R3 long frame readback");
    run_frame(16, {16'b0, 3'b111, 1'b0, 4'd9, 8'hC3}, "R3 long frame 16");

    // Short frame ignored
    run_frame(12, {20'b0, 1'b0, 4'd2, 7'h55}, "R4 short frame");
    rdf(1, 8'h00, "R4 readback address kept");

    // Clock activity while deselected
    ser_cs_n = 1'b1;
    for (int i = 0; i < 13; i++) begin
      ser_din = (i % 3) == 0;
      ser_clk = 1'b1; waitn(6);
      ser_clk = 1'b0; waitn(6);
    end
    check(cfg_regs == model_flat(), "R9 clocks while deselected", cfg_regs, model_flat());
    run_frame(5, {27'b0, 5'b10110}, "R9 frame starts empty");

    // Output enable off
    wr(8, 8'h00, "R2 write control off");
    rdf(12, 8'h00, "R7 oe disabled");
    wr(12, 8'h3C, "R7 oe disabled write");
    wr(8, 8'h48, "R2 control back on");
    wr(6, 8'h11, "R8 protected again");
    rdf(14, 8'h00, "R6 final readback");
    rdf(0, 8'h00, "R6 final readback");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule